// File: doc/BRIEF.md
# Memory Power Sleep-State Sequencer

This block decides the operating mode of a memory power subsystem that has three rails. The main switching rail feeds memory. A termination regulator tracks half of the main rail. A core switching rail feeds the memory controller. The block does not regulate anything itself. It reads two active-low sleep requests and a set of supply, regulation and fault flags. From these it selects one of three modes: full run, standby, or shutdown. It then drives the rail enables, a drive-state code for each rail's outputs, a soft-start request and a request to double the main rail's switching frequency.

The two sleep requests arrive asynchronously. Each one passes through a two-flop synchroniser and a stability filter before the mode logic acts on it. The supply-good flags, the regulation flags and the fault flags are treated as synchronous inputs.

The block brings up the secondary rails only after the main rail has finished soft-start and reports regulation. An overcurrent event while running latches every rail off. Only a supply drop or a shutdown request clears that latch. An over-temperature flag turns all rails off for as long as it is high.

Top module: `acpi_pwr_seq`

## Requirements
- R1: After reset the mode is shutdown and all three enables, `ss_req_o` and `freq_dbl_o` are 0. The mode code is 2'b00 for shutdown, 2'b01 for run and 2'b10 for standby. Code 2'b11 never appears.
- R2: The mode stays in shutdown, or returns to it, whenever `ref_good_i` or `main_good_i` is low. `boot_good_i` is considered only while both of those flags are high.
- R3: The mode moves from shutdown to run, and from standby to run, only when `stby_req_ni`=1, `off_req_ni`=1 and `boot_good_i`=1.
- R4: The mode moves from run to standby when `stby_req_ni`=0 and `off_req_ni`=1. In standby, losing `boot_good_i` leaves the mode in standby.
- R5: `off_req_ni`=0 forces shutdown from any mode. In run mode, `stby_req_ni`=1 together with `boot_good_i`=0 also forces shutdown. No other input combination changes the mode.
- R6: A change on a sleep input takes effect only after it has held for STABLE_CYC consecutive cycles past the synchroniser. A pulse shorter than that leaves the mode unchanged.
- R7: On entry to run, `main_en_o` and `ss_req_o` go high while `term_en_o` and `core_en_o` stay low. The two secondary enables rise, and `ss_req_o` falls, only after `in_reg_i` and `ss_done_i` are both high.
- R8: The drive codes are 2'b00 = held low, 2'b01 = switching, 2'b10 = standby and 2'b11 = high impedance. In run mode the main and core rails switch once enabled and the termination output is driven. In standby the main rail is in standby, the termination output is high impedance and the core rail is held low. In shutdown the main and core rails are held low and the termination output is high impedance.
- R9: `freq_dbl_o` is 1 only in standby. An `ocp_i` pulse in standby or shutdown has no effect on any output.
- R10: `ocp_i` in run mode latches every rail off: enables 0, main and core held low, termination high impedance. The latch persists until `main_good_i` falls, `boot_good_i` falls or `off_req_ni` is seen low.
- R11: While `ot_i` is high every enable and request is 0 and every rail is off. When `ot_i` falls, operation resumes in the current mode and the secondary rails are sequenced again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_good_i | input | 1 | Internal reference settled |
| main_good_i | input | 1 | Main (always-on) supply good |
| boot_good_i | input | 1 | Gate-drive boot supply good |
| stby_req_ni | input | 1 | Active-low standby request (async) |
| off_req_ni | input | 1 | Active-low shutdown request (async) |
| ss_done_i | input | 1 | Main rail soft-start complete |
| in_reg_i | input | 1 | Main rail in regulation |
| ocp_i | input | 1 | Main rail overcurrent strobe |
| ot_i | input | 1 | Over-temperature flag (hysteresis applied upstream) |
| mode_o | output | 2 | Mode: 00 shutdown, 01 run, 10 standby |
| main_en_o | output | 1 | Main rail enable |
| term_en_o | output | 1 | Termination regulator enable |
| core_en_o | output | 1 | Core rail enable |
| main_drv_o | output | 2 | Main rail drive code |
| term_drv_o | output | 2 | Termination drive code |
| core_drv_o | output | 2 | Core rail drive code |
| ss_req_o | output | 1 | Main rail soft-start request |
| freq_dbl_o | output | 1 | Double main switching frequency |

## Verification
The bench targets several corner cases of the mode logic and the fault handling:

- Run mode with `boot_good_i` lost but no standby request. A design that treated this like standby would stay up instead of shutting down.
- Standby with the boot supply gone. A design that leaves standby here breaks the low-power state.
- A sleep pulse two cycles shorter than the filter window. A missing filter would change mode on this glitch.
- An overcurrent strobe in standby. A design that latched it there would refuse to come back to run.
- The three ways of clearing the overcurrent latch, and over-temperature recovery. Each must restart the soft-start request before the secondary rails return; a missed sequencing reset would bring the termination and core rails up early.

Randomised phases change the sleep inputs and the supply flags in separate steps, and compare every output against a reference model.

// File: rtl/acpi_seq_pkg.sv
package acpi_seq_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_RUN  = 2'b01,
    MODE_STBY = 2'b10
  } mode_e;

  typedef enum logic [1:0] {
    DRV_LOW  = 2'b00,
    DRV_SW   = 2'b01,
    DRV_STBY = 2'b10,
    DRV_HIZ  = 2'b11
  } drv_e;
endpackage

// File: rtl/sleep_filter.sv
module sleep_filter #(
  parameter int STABLE_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic lvl_o
);
  localparam int CW = $clog2(STABLE_CYC + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(STABLE_CYC - 1);

  logic          sync1_q, sync2_q, lvl_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      lvl_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      sync1_q <= raw_i;
      sync2_q <= sync1_q;
      if (sync2_q == lvl_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_TOP) begin
        lvl_q <= sync2_q;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
  import acpi_seq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  mon_ok_i,
  input  logic  boot_good_i,
  input  logic  stby_n_i,
  input  logic  off_n_i,
  output mode_e mode_o
);
  mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (!mon_ok_i || !off_n_i) begin
      mode_d = MODE_OFF;
    end else begin
      unique case (mode_q)
        MODE_OFF:  if (stby_n_i && boot_good_i) mode_d = MODE_RUN;
        MODE_RUN: begin
          if (!stby_n_i)        mode_d = MODE_STBY;
          else if (!boot_good_i) mode_d = MODE_OFF;
        end
        MODE_STBY: if (stby_n_i && boot_good_i) mode_d = MODE_RUN;
        default:   mode_d = MODE_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_OFF;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/fault_latch.sv
module fault_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic main_good_i,
  input  logic boot_good_i,
  input  logic off_n_i,
  output logic fault_o
);
  logic main_prev_q, boot_prev_q, off_prev_q, fault_q;
  logic recycle;

  // A drop of a supply or the shutdown request counts as a recycle
  assign recycle = (main_prev_q & ~main_good_i) |
                   (boot_prev_q & ~boot_good_i) |
                   (off_prev_q  & ~off_n_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_prev_q <= 1'b0;
      boot_prev_q <= 1'b0;
      off_prev_q  <= 1'b0;
      fault_q     <= 1'b0;
    end else begin
      main_prev_q <= main_good_i;
      boot_prev_q <= boot_good_i;
      off_prev_q  <= off_n_i;
      if (set_i)        fault_q <= 1'b1;
      else if (recycle) fault_q <= 1'b0;
    end
  end

  assign fault_o = fault_q;
endmodule

// File: rtl/rail_ctrl.sv
module rail_ctrl
  import acpi_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  mode_e      mode_i,
  input  logic       shut_i,
  input  logic       in_reg_i,
  input  logic       ss_done_i,
  output logic       main_en_o,
  output logic       term_en_o,
  output logic       core_en_o,
  output logic [1:0] main_drv_o,
  output logic [1:0] term_drv_o,
  output logic [1:0] core_drv_o,
  output logic       ss_req_o,
  output logic       freq_dbl_o
);
  logic sec_on_q;
  logic run;

  assign run = (mode_i == MODE_RUN) && !shut_i;

  // Secondary rails follow only once the main rail is up
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 sec_on_q <= 1'b0;
    else if (!run)               sec_on_q <= 1'b0;
    else if (in_reg_i && ss_done_i) sec_on_q <= 1'b1;
  end

  assign main_en_o  = !shut_i && (mode_i != MODE_OFF);
  assign term_en_o  = run && sec_on_q;
  assign core_en_o  = run && sec_on_q;
  assign ss_req_o   = run && !sec_on_q;
  assign freq_dbl_o = !shut_i && (mode_i == MODE_STBY);

  always_comb begin
    main_drv_o = DRV_LOW;
    if (!shut_i) begin
      unique case (mode_i)
        MODE_RUN:  main_drv_o = DRV_SW;
        MODE_STBY: main_drv_o = DRV_STBY;
        default:   main_drv_o = DRV_LOW;
      endcase
    end
  end

  assign term_drv_o = term_en_o ? DRV_SW : DRV_HIZ;
  assign core_drv_o = core_en_o ? DRV_SW : DRV_LOW;
endmodule

// File: rtl/acpi_pwr_seq.sv
module acpi_pwr_seq
  import acpi_seq_pkg::*;
#(
  parameter int STABLE_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_good_i,
  input  logic       main_good_i,
  input  logic       boot_good_i,
  input  logic       stby_req_ni,
  input  logic       off_req_ni,
  input  logic       ss_done_i,
  input  logic       in_reg_i,
  input  logic       ocp_i,
  input  logic       ot_i,
  output logic [1:0] mode_o,
  output logic       main_en_o,
  output logic       term_en_o,
  output logic       core_en_o,
  output logic [1:0] main_drv_o,
  output logic [1:0] term_drv_o,
  output logic [1:0] core_drv_o,
  output logic       ss_req_o,
  output logic       freq_dbl_o
);
  localparam int NSLP = 2;

  logic [NSLP-1:0] slp_raw, slp_lvl;
  mode_e           mode;
  logic            fault, shut, mon_ok;

  assign slp_raw = {off_req_ni, stby_req_ni};

  for (genvar g = 0; g < NSLP; g++) begin : g_slp
    sleep_filter #(.STABLE_CYC(STABLE_CYC)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (slp_raw[g]),
      .lvl_o (slp_lvl[g])
    );
  end

  // Boot supply is only looked at once reference and main supply are good
  assign mon_ok = ref_good_i && main_good_i;

  mode_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mon_ok_i   (mon_ok),
    .boot_good_i(boot_good_i),
    .stby_n_i   (slp_lvl[0]),
    .off_n_i    (slp_lvl[1]),
    .mode_o     (mode)
  );

  fault_latch u_fault (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (ocp_i && (mode == MODE_RUN)),
    .main_good_i(main_good_i),
    .boot_good_i(boot_good_i),
    .off_n_i    (slp_lvl[1]),
    .fault_o    (fault)
  );

  assign shut = fault || ot_i;

  rail_ctrl u_rail (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode),
    .shut_i    (shut),
    .in_reg_i  (in_reg_i),
    .ss_done_i (ss_done_i),
    .main_en_o (main_en_o),
    .term_en_o (term_en_o),
    .core_en_o (core_en_o),
    .main_drv_o(main_drv_o),
    .term_drv_o(term_drv_o),
    .core_drv_o(core_drv_o),
    .ss_req_o  (ss_req_o),
    .freq_dbl_o(freq_dbl_o)
  );

  assign mode_o = mode;
endmodule

// File: rtl/acpi_seq_chk.sv
module acpi_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ref_good_i,
  input logic       ocp_i,
  input logic       ot_i,
  input logic [1:0] mode_o,
  input logic       main_en_o,
  input logic       term_en_o,
  input logic       core_en_o,
  input logic       ss_req_o,
  input logic       freq_dbl_o
);
  localparam logic [1:0] M_OFF = 2'b00, M_RUN = 2'b01, M_STBY = 2'b10;

  p_legal_mode_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'b11);

  p_mon_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_good_i |=> mode_o == M_OFF);

  p_off_exit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_o) == M_OFF) |-> mode_o != M_STBY);

  p_sec_after_main_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_en_o |-> (mode_o == M_RUN) && main_en_o && core_en_o);

  p_run_entry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_o == M_RUN) && ($past(mode_o) != M_RUN)) |-> !term_en_o && !core_en_o);

  p_dbl_stby_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freq_dbl_o |-> mode_o == M_STBY);

  p_ocp_latch_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_o == M_RUN) && ocp_i) |=> !main_en_o && !term_en_o && !core_en_o);

  p_ot_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ot_i |-> !main_en_o && !term_en_o && !core_en_o && !ss_req_o);
endmodule

bind acpi_pwr_seq acpi_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ref_good_i(ref_good_i),
  .ocp_i     (ocp_i),
  .ot_i      (ot_i),
  .mode_o    (mode_o),
  .main_en_o (main_en_o),
  .term_en_o (term_en_o),
  .core_en_o (core_en_o),
  .ss_req_o  (ss_req_o),
  .freq_dbl_o(freq_dbl_o)
);

// File: tb/tb_acpi_pwr_seq.sv
module tb_acpi_pwr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int STABLE     = 4;
  localparam int SLP_WAIT   = STABLE + 6;
  localparam int FLG_WAIT   = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_good = 0, main_good = 0, boot_good = 0, stby_n = 0, off_n = 0;
  logic ss_done = 0, in_reg = 0, ocp = 0, ot = 0;
  logic [1:0] mode, main_drv, term_drv, core_drv;
  logic main_en, term_en, core_en, ss_req, freq_dbl;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acpi_pwr_seq #(.STABLE_CYC(STABLE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_good_i(ref_good), .main_good_i(main_good),
    .boot_good_i(boot_good), .stby_req_ni(stby_n), .off_req_ni(off_n),
    .ss_done_i(ss_done), .in_reg_i(in_reg), .ocp_i(ocp), .ot_i(ot),
    .mode_o(mode), .main_en_o(main_en), .term_en_o(term_en), .core_en_o(core_en),
    .main_drv_o(main_drv), .term_drv_o(term_drv), .core_drv_o(core_drv),
    .ss_req_o(ss_req), .freq_dbl_o(freq_dbl));

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [1:0] nx(logic [1:0] m, bit r, bit mg, bit bg, bit s3, bit s5);
    if (!(r && mg) || !s5) return 2'd0;
    case (m)
      2'd0: return (s3 && bg) ? 2'd1 : 2'd0;
      2'd1: if (!s3) return 2'd2; else if (!bg) return 2'd0; else return 2'd1;
      2'd2: return (s3 && bg) ? 2'd1 : 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  // Checks all outputs for a fault-free, cool state
  task automatic chk_all(string req, logic [1:0] em, bit sec);
    bit run = (em == 2'd1);
    chk(req, "mode", mode, em);
    chk(req, "main_en", main_en, em != 2'd0);
    chk(req, "term_en", term_en, run && sec);
    chk(req, "core_en", core_en, run && sec);
    chk(req, "ss_req", ss_req, run && !sec);
    chk(req, "freq_dbl", freq_dbl, em == 2'd2);
    chk(req, "main_drv", main_drv, run ? 1 : (em == 2'd2 ? 2 : 0));
    chk(req, "term_drv", term_drv, (run && sec) ? 1 : 3);
    chk(req, "core_drv", core_drv, (run && sec) ? 1 : 0);
  endtask

  task automatic chk_dark(string req);
    chk(req, "main_en", main_en, 0);
    chk(req, "term_en", term_en, 0);
    chk(req, "core_en", core_en, 0);
    chk(req, "main_drv", main_drv, 0);
    chk(req, "term_drv", term_drv, 3);
    chk(req, "core_drv", core_drv, 0);
  endtask

  initial begin
    logic [1:0] em;
    bit sec;
    wt(2);
    // R1 reset state
    chk_all("R1", 2'd0, 0);
    rst_n = 1;
    stby_n = 1; off_n = 1; main_good = 1; boot_good = 1;
    wt(SLP_WAIT);
    // R2: no reference, stays off
    chk("R2", "mode no ref", mode, 0);
    ref_good = 1; wt(FLG_WAIT);
    chk_all("R3", 2'd1, 0);
    main_good = 0; wt(FLG_WAIT);
    chk("R2", "mode main lost", mode, 0);
    boot_good = 0; main_good = 1; wt(FLG_WAIT);
    chk("R3", "mode no boot", mode, 0);
    boot_good = 1; wt(FLG_WAIT);
    // R7 sequencing
    chk_all("R7", 2'd1, 0);
    in_reg = 1; wt(FLG_WAIT);
    chk_all("R7", 2'd1, 0);
    ss_done = 1; wt(FLG_WAIT);
    chk_all("R7", 2'd1, 1);
    // R6 glitch shorter than window
    stby_n = 0; wt(STABLE - 2); stby_n = 1; wt(SLP_WAIT);
    chk_all("R6", 2'd1, 1);
    // R4 standby
    stby_n = 0; wt(SLP_WAIT);
    chk_all("R4", 2'd2, 0);
    chk("R8", "term hiz stby", term_drv, 3);
    boot_good = 0; wt(FLG_WAIT);
    chk("R4", "stay stby no boot", mode, 2);
    boot_good = 1; wt(FLG_WAIT);
    ocp = 1; wt(1); ocp = 0; wt(FLG_WAIT);
    chk("R9", "ocp ignored stby", main_en, 1);
    stby_n = 1; wt(SLP_WAIT);
    chk_all("R9", 2'd1, 1);
    // R5 boot loss in run
    boot_good = 0; wt(FLG_WAIT);
    chk_all("R5", 2'd0, 0);
    boot_good = 1; wt(FLG_WAIT);
    chk_all("R3", 2'd1, 1);
    // R10 ocp latch, clear via shutdown request
    ocp = 1; wt(1); ocp = 0; wt(FLG_WAIT);
    chk("R10", "mode", mode, 1);
    chk_dark("R10");
    chk("R10", "ss_req", ss_req, 0);
    off_n = 0; wt(SLP_WAIT);
    chk_all("R5", 2'd0, 0);
    off_n = 1; wt(SLP_WAIT);
    chk("R10", "cleared by off", main_en, 1);
    // clear via main supply
    ocp = 1; wt(1); ocp = 0; wt(FLG_WAIT);
    chk_dark("R10");
    main_good = 0; wt(FLG_WAIT); main_good = 1; wt(FLG_WAIT);
    chk_all("R10", 2'd1, 1);
    // clear via boot supply
    ocp = 1; wt(1); ocp = 0; wt(FLG_WAIT);
    chk("R10", "latched", main_en, 0);
    boot_good = 0; wt(FLG_WAIT); boot_good = 1; wt(FLG_WAIT);
    chk_all("R10", 2'd1, 1);
    // R11 over-temperature
    in_reg = 0; ot = 1; wt(FLG_WAIT);
    chk_dark("R11");
    chk("R11", "ss_req", ss_req, 0);
    ot = 0; wt(FLG_WAIT);
    chk_all("R11", 2'd1, 0);
    in_reg = 1; wt(FLG_WAIT);
    chk_all("R11", 2'd1, 1);
    // R5 off from standby
    stby_n = 0; wt(SLP_WAIT);
    off_n = 0; wt(SLP_WAIT);
    chk_all("R5", 2'd0, 0);
    off_n = 1; stby_n = 1; wt(SLP_WAIT);
    em = mode; sec = term_en;

    // Random phases: sleep inputs first, then flags
    void'($urandom(32'h5eed_1234));
    for (int it = 0; it < 80; it++) begin
      bit s3 = ($urandom % 3) != 0;
      bit s5 = ($urandom % 5) != 0;
      stby_n = s3; off_n = s5;
      wt(SLP_WAIT);
      for (int k = 0; k < 4; k++) begin
        if (em != 2'd1) sec = 0; else if (in_reg && ss_done) sec = 1;
        em = nx(em, ref_good, main_good, boot_good, stby_n, off_n);
      end
      if (em != 2'd1) sec = 0; else if (in_reg && ss_done) sec = 1;
      chk_all("R3", em, sec);
      ref_good = ($urandom % 10) != 0;
      main_good = ($urandom % 8) != 0;
      boot_good = ($urandom % 3) != 0;
      in_reg = $urandom % 2;
      ss_done = $urandom % 2;
      wt(FLG_WAIT);
      for (int k = 0; k < 4; k++) begin
        if (em != 2'd1) sec = 0; else if (in_reg && ss_done) sec = 1;
        em = nx(em, ref_good, main_good, boot_good, stby_n, off_n);
      end
      if (em != 2'd1) sec = 0; else if (in_reg && ss_done) sec = 1;
      chk_all("R5", em, sec);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule